// File: doc/BRIEF.md
# Configuration Record Fetch Engine

This block loads a network controller's startup configuration from the controller's local byte-addressed buffer memory. When software raises the initialization request, the engine builds a 24-bit record address from two control register values. It then walks the record with twelve 16-bit reads over a simple request/acknowledge memory port. The results are the mode word, the 48-bit station address, the 64-bit multicast filter, and the base address and entry count of the receive and transmit descriptor rings.

When the last word arrives, the engine pulses `done`. That pulse tells the packet engines to restart both ring indices at zero. In the same cycle the engine sets the sticky init-done status bit and applies the mode word's enable and loopback bits. A record address with bit 0 set is rejected: the engine raises an alignment error and makes no memory request.

Top module: `cfg_fetch_top`

## Requirements
- R1: The record base is `{base_hi[7:0], base_lo}`, and `base_hi[15:8]` is ignored. Twelve reads are issued in order, read k at byte address (base + 2k) modulo 2^BUF_AW, so the sequence wraps past the top of the buffer.
- R2: `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_ack` is high. `mem_rdata` is taken in that cycle, with `mem_rdata[7:0]` the byte at the even address and `mem_rdata[15:8]` the byte at the odd address.
- R3: With w0..w11 the words in read order, the outputs are:
  - `mode_word` = w0
  - `station_addr` = {w3,w2,w1}
  - `mcast_filter` = {w7,w6,w5,w4}
  - `rx_ring_base` = {w9[7:0],w8} and `tx_ring_base` = {w11[7:0],w10}
  - `rx_ring_len` = 2^w9[15:13] and `tx_ring_len` = 2^w11[15:13], each from 1 to 128.
- R4: In the cycle `done` is high, `tx_on` becomes NOT mode bit 1, `rx_on` becomes NOT mode bit 0, and `loopback` becomes mode bit 2.
- R5: `done` is a single-cycle pulse in the cycle after the twelfth acknowledge. In that cycle `init_done` is 1 and `busy` is 0.
- R6: `busy` rises in the cycle after an accepted `init_start` and stays high until `done`. A request while busy is ignored: the address sequence continues unchanged. `mem_req` is never high while `busy` is low.
- R7: An `init_start` while idle with an odd base sets `align_err`, leaves `busy` low and issues no request. An accepted start with an even base clears `align_err`.
- R8: `init_done` stays set until `idon_clr` is pulsed. A `done` in the same cycle takes priority over the clear.
- R9: After reset, `busy`, `mem_req`, `done`, `align_err`, `init_done`, `tx_on`, `rx_on` and `loopback` are 0. The record fields are 0 and both ring counts are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start | input | 1 | Initialization request |
| base_lo | input | 16 | Record address bits 15:0 |
| base_hi | input | 16 | Control value whose low byte gives record address bits 23:16 |
| idon_clr | input | 1 | Clears init_done |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | BUF_AW | Byte address of the word read |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 16 | Read word, low byte from the even address |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse, also restarts ring indices |
| align_err | output | 1 | Last request had an odd base |
| init_done | output | 1 | Sticky initialization-complete status |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| loopback | output | 1 | Loopback mode selected |
| mode_word | output | 16 | Mode word |
| station_addr | output | 48 | Station address |
| mcast_filter | output | 64 | Multicast filter |
| rx_ring_base | output | 24 | Receive ring base address |
| rx_ring_len | output | 8 | Receive ring entry count |
| tx_ring_base | output | 24 | Transmit ring base address |
| tx_ring_len | output | 8 | Transmit ring entry count |

## Verification
A wrong word index or address counter shows on `mem_addr` at the next request. It also shows later as a field holding a neighbouring word, which the field checks at `done` catch. A sequencer that miscounts shows a `done` that comes early or late against the twelfth acknowledge, or a `busy` that drops too soon. A bad start decision shows one cycle after the request: a fetch that starts from an odd base, or a restart in mid-record that breaks the expected address order. Random memory latency and random record contents exercise every field bit and each combination of the mode's enable bits.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;
  localparam int REC_WORDS = 12;
  localparam int WIDX_W    = $clog2(REC_WORDS);
  localparam int ADDR24_W  = 24;
  localparam int LEN_W     = 8;

  // word positions inside the record (order is what the reads walk)
  localparam int W_MODE = 0;
  localparam int W_STA  = 1;
  localparam int W_MCF  = 4;
  localparam int W_RXLO = 8;
  localparam int W_RXHI = 9;
  localparam int W_TXLO = 10;
  localparam int W_TXHI = 11;

  typedef enum logic {FS_IDLE = 1'b0, FS_READ = 1'b1} fetch_state_e;

  typedef logic [REC_WORDS-1:0][15:0] rec_words_t;
endpackage

// File: rtl/cfg_fetch_rst_sync.sv
module cfg_fetch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
  import cfg_fetch_pkg::*;
#(
  parameter int BUF_AW = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR24_W-1:0] base,
  input  logic                mem_ack,
  output logic                busy,
  output logic                mem_req,
  output logic [BUF_AW-1:0]   mem_addr,
  output logic                cap_en,
  output logic [WIDX_W-1:0]   cap_idx,
  output logic                last,
  output logic                align_err
);
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(REC_WORDS - 1);
  localparam logic [BUF_AW-1:0] STEP     = BUF_AW'(2);

  fetch_state_e        st_q, st_d;
  logic [WIDX_W-1:0]   idx_q, idx_d;
  logic [BUF_AW-1:0]   addr_q, addr_d;
  logic                aerr_q, aerr_d;
  logic                accept;

  assign accept = start && (st_q == FS_IDLE);
  assign cap_en = (st_q == FS_READ) && mem_ack;
  assign last   = cap_en && (idx_q == LAST_IDX);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    aerr_d = aerr_q;
    if (accept) begin
      aerr_d = base[0];
      if (!base[0]) begin
        st_d   = FS_READ;
        idx_d  = '0;
        addr_d = base[BUF_AW-1:0];
      end
    end else if (cap_en) begin
      addr_d = addr_q + STEP;
      idx_d  = idx_q + WIDX_W'(1);
      if (last) st_d = FS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      idx_q  <= '0;
      addr_q <= '0;
      aerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
      aerr_q <= aerr_d;
    end
  end

  assign busy      = (st_q == FS_READ);
  assign mem_req   = busy;
  assign mem_addr  = addr_q;
  assign cap_idx   = idx_q;
  assign align_err = aerr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !last |=> (mem_addr - $past(mem_addr)) == STEP); // R1
  AST_ODD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && base[0] |=> !busy && align_err); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy); // R6
endmodule

// File: rtl/cfg_fetch_store.sv
module cfg_fetch_store
  import cfg_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WIDX_W-1:0] cap_idx,
  input  logic [15:0]       rdata,
  output rec_words_t        words
);
  for (genvar gi = 0; gi < REC_WORDS; gi++) begin : g_word
    logic        we;
    logic [15:0] word_q;
    assign we = cap_en && (cap_idx == WIDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (we) word_q <= rdata;
    end
    assign words[gi] = word_q;
  end
endmodule

// File: rtl/cfg_fetch_decode.sv
module cfg_fetch_decode
  import cfg_fetch_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  rec_words_t          words,
  output logic [15:0]         mode_word,
  output logic [47:0]         station_addr,
  output logic [63:0]         mcast_filter,
  output logic [ADDR24_W-1:0] rx_ring_base,
  output logic [LEN_W-1:0]    rx_ring_len,
  output logic [ADDR24_W-1:0] tx_ring_base,
  output logic [LEN_W-1:0]    tx_ring_len
);
  function automatic logic [LEN_W-1:0] ring_count(input logic [2:0] lg);
    return LEN_W'(1) << lg;
  endfunction

  always_comb begin
    mode_word    = words[W_MODE];
    station_addr = {words[W_STA+2], words[W_STA+1], words[W_STA]};
    mcast_filter = {words[W_MCF+3], words[W_MCF+2], words[W_MCF+1], words[W_MCF]};
    rx_ring_base = {words[W_RXHI][7:0], words[W_RXLO]};
    tx_ring_base = {words[W_TXHI][7:0], words[W_TXLO]};
    rx_ring_len  = ring_count(words[W_RXHI][15:13]);
    tx_ring_len  = ring_count(words[W_TXHI][15:13]);
  end

  AST_RX_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_ring_len) == 1); // R3
  AST_TX_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_ring_len) == 1); // R3
endmodule

// File: rtl/cfg_fetch_top.sv
module cfg_fetch_top
  import cfg_fetch_pkg::*;
#(
  parameter int BUF_AW = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_start,
  input  logic [15:0]         base_lo,
  input  logic [15:0]         base_hi,
  input  logic                idon_clr,
  output logic                mem_req,
  output logic [BUF_AW-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [15:0]         mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                align_err,
  output logic                init_done,
  output logic                tx_on,
  output logic                rx_on,
  output logic                loopback,
  output logic [15:0]         mode_word,
  output logic [47:0]         station_addr,
  output logic [63:0]         mcast_filter,
  output logic [ADDR24_W-1:0] rx_ring_base,
  output logic [LEN_W-1:0]    rx_ring_len,
  output logic [ADDR24_W-1:0] tx_ring_base,
  output logic [LEN_W-1:0]    tx_ring_len
);
  logic                rst_ns;
  logic [ADDR24_W-1:0] rec_base;
  logic                cap_en, last;
  logic [WIDX_W-1:0]   cap_idx;
  rec_words_t          words;

  logic done_q, done_d, idon_q, idon_d;
  logic txon_q, txon_d, rxon_q, rxon_d, lpbk_q, lpbk_d;

  assign rec_base = {base_hi[7:0], base_lo};

  cfg_fetch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  cfg_fetch_seq #(.BUF_AW(BUF_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (init_start),
    .base      (rec_base),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .last      (last),
    .align_err (align_err)
  );

  cfg_fetch_store u_store (
    .clk     (clk),
    .rst_n   (rst_ns),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .rdata   (mem_rdata),
    .words   (words)
  );

  cfg_fetch_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_ns),
    .words        (words),
    .mode_word    (mode_word),
    .station_addr (station_addr),
    .mcast_filter (mcast_filter),
    .rx_ring_base (rx_ring_base),
    .rx_ring_len  (rx_ring_len),
    .tx_ring_base (tx_ring_base),
    .tx_ring_len  (tx_ring_len)
  );

  // status update: the mode word is already stored when the last word lands
  always_comb begin
    done_d = last;
    idon_d = idon_q;
    txon_d = txon_q;
    rxon_d = rxon_q;
    lpbk_d = lpbk_q;
    if (idon_clr) idon_d = 1'b0;
    if (last) begin
      idon_d = 1'b1;
      txon_d = ~mode_word[1];
      rxon_d = ~mode_word[0];
      lpbk_d = mode_word[2];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      done_q <= 1'b0;
      idon_q <= 1'b0;
      txon_q <= 1'b0;
      rxon_q <= 1'b0;
      lpbk_q <= 1'b0;
    end else begin
      done_q <= done_d;
      idon_q <= idon_d;
      txon_q <= txon_d;
      rxon_q <= rxon_d;
      lpbk_q <= lpbk_d;
    end
  end

  assign done      = done_q;
  assign init_done = idon_q;
  assign tx_on     = txon_q;
  assign rx_on     = rxon_q;
  assign loopback  = lpbk_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done); // R5
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> init_done && !busy); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> !mem_req); // R6
  AST_TX_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> tx_on == !mode_word[1] && rx_on == !mode_word[0]); // R4
endmodule

// File: tb/cfg_fetch_top_bench.sv
module cfg_fetch_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n;
  logic init_start, idon_clr, mem_ack;
  logic [15:0] base_lo, base_hi, mem_rdata;
  logic mem_req, busy, done, align_err, init_done, tx_on, rx_on, loopback;
  logic [AW-1:0] mem_addr;
  logic [15:0] mode_word;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;
  logic [23:0] rx_ring_base, tx_ring_base;
  logic [7:0]  rx_ring_len, tx_ring_len;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] key;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_fetch_top #(.BUF_AW(AW)) u_cfg_fetch_top (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .base_lo(base_lo),
    .base_hi(base_hi), .idon_clr(idon_clr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .align_err(align_err), .init_done(init_done),
    .tx_on(tx_on), .rx_on(rx_on), .loopback(loopback), .mode_word(mode_word),
    .station_addr(station_addr), .mcast_filter(mcast_filter),
    .rx_ring_base(rx_ring_base), .rx_ring_len(rx_ring_len),
    .tx_ring_base(tx_ring_base), .tx_ring_len(tx_ring_len)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [31:0] h;
    h = ({15'd0, a} * 32'h9E3779B1) ^ key;
    h = h ^ (h >> 13);
    return h[7:0] ^ h[23:16];
  endfunction

  function automatic logic [AW-1:0] rec_addr(input logic [23:0] b, input int k);
    logic [23:0] s;
    s = b + 24'(2 * k);
    return s[AW-1:0];
  endfunction

  function automatic logic [15:0] word_at(input logic [AW-1:0] a);
    return {mem_byte(a + AW'(1)), mem_byte(a)};
  endfunction

  function automatic logic [7:0] ring_len(input logic [15:0] hi_word);
    return 8'd1 << hi_word[15:13];
  endfunction

  task automatic check_fields(input logic [23:0] b);
    logic [15:0] w [12];
    for (int k = 0; k < 12; k++) w[k] = word_at(rec_addr(b, k));
    chk(mode_word == w[0], "R3 mode", 64'(mode_word), 64'(w[0]));
    chk(station_addr == {w[3], w[2], w[1]}, "R3 station",
        64'(station_addr), 64'({w[3], w[2], w[1]}));
    chk(mcast_filter == {w[7], w[6], w[5], w[4]}, "R3 mcast",
        mcast_filter, {w[7], w[6], w[5], w[4]});
    chk(rx_ring_base == {w[9][7:0], w[8]}, "R3 rxbase",
        64'(rx_ring_base), 64'({w[9][7:0], w[8]}));
    chk(tx_ring_base == {w[11][7:0], w[10]}, "R3 txbase",
        64'(tx_ring_base), 64'({w[11][7:0], w[10]}));
    chk(rx_ring_len == ring_len(w[9]), "R3 rxlen",
        64'(rx_ring_len), 64'(ring_len(w[9])));
    chk(tx_ring_len == ring_len(w[11]), "R3 txlen",
        64'(tx_ring_len), 64'(ring_len(w[11])));
    chk(tx_on == !w[0][1], "R4 tx_on", 64'(tx_on), 64'(!w[0][1]));
    chk(rx_on == !w[0][0], "R4 rx_on", 64'(rx_on), 64'(!w[0][0]));
    chk(loopback == w[0][2], "R4 loopback", 64'(loopback), 64'(w[0][2]));
    chk(init_done && !busy, "R5 status", 64'({init_done, busy}), 64'(2'b10));
  endtask

  task automatic run_fetch(input logic [15:0] lo, input logic [15:0] hi, input bit poke);
    logic [23:0] b;
    int  n, lat;
    bit  pending, fin;
    b = {hi[7:0], lo};
    n = 0; lat = 0; pending = 0; fin = 0;
    @(negedge clk);
    base_lo = lo; base_hi = hi; init_start = 1'b1;
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        init_start = 1'b0;
        chk(busy == 1'b1, "R6 busy rise", 64'(busy), 64'd1);
        chk(align_err == 1'b0, "R7 clear", 64'(align_err), 64'd0);
      end
      if (poke && cyc == 3) begin
        init_start = 1'b1; base_lo = lo ^ 16'h0100; base_hi = hi ^ 16'h0011;
      end
      if (poke && cyc == 4) begin
        init_start = 1'b0; base_lo = lo; base_hi = hi;
      end
      if (done) begin
        fin = 1;
        chk(n == 12, "R5 read count", 64'(n), 64'd12);
        check_fields(b);
      end else if (busy !== 1'b1) begin
        chk(1'b0, "R6 busy held", 64'(busy), 64'd1);
      end
      if (mem_req) begin
        if (!pending) begin
          chk(mem_addr == rec_addr(b, n), "R1 address",
              64'(mem_addr), 64'(rec_addr(b, n)));
          pending = 1; lat = int'($urandom % 3);
        end else begin
          chk(mem_addr == rec_addr(b, n), "R2 hold",
              64'(mem_addr), 64'(rec_addr(b, n)));
        end
        if (lat == 0) begin
          mem_ack = 1'b1; mem_rdata = word_at(mem_addr); pending = 0; n++;
        end else begin
          lat--; mem_ack = 1'b0; mem_rdata = $urandom;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
    if (!fin) chk(1'b0, "R5 no done", 64'd0, 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R5 pulse", 64'(done), 64'd0);
    chk(mem_req == 1'b0, "R6 idle req", 64'(mem_req), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; init_start = 1'b0; idon_clr = 1'b0; mem_ack = 1'b0;
    base_lo = '0; base_hi = '0; mem_rdata = '0; key = 32'h5a5a_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk({busy, mem_req, done, align_err, init_done, tx_on, rx_on, loopback} == 8'd0,
        "R9 flags", 64'({busy, mem_req, done, align_err, init_done, tx_on, rx_on, loopback}), 64'd0);
    chk(station_addr == 48'd0 && mode_word == 16'd0, "R9 fields",
        64'(station_addr), 64'd0);
    chk(rx_ring_len == 8'd1 && tx_ring_len == 8'd1, "R9 lens",
        64'({rx_ring_len, tx_ring_len}), 64'h0101);

    // R7 odd base rejected
    @(negedge clk);
    base_lo = 16'h1235; base_hi = 16'h0002; init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    chk(align_err == 1'b1, "R7 set", 64'(align_err), 64'd1);
    chk(busy == 1'b0, "R7 no busy", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R7 no request", 64'(mem_req), 64'd0);

    // R1 wrap past top of buffer, upper control byte ignored
    key = 32'hC0FF_EE01;
    run_fetch(16'hFFFA, 16'hA5FF, 1'b0);
    // base zero
    key = 32'h0BAD_F00D;
    run_fetch(16'h0000, 16'h0000, 1'b0);

    // R8 clear of init_done
    @(negedge clk);
    idon_clr = 1'b1;
    @(negedge clk);
    idon_clr = 1'b0;
    chk(init_done == 1'b0, "R8 clear", 64'(init_done), 64'd0);

    // random records, some with a request poked in while busy (R6)
    for (int t = 0; t < 40; t++) begin
      logic [15:0] lo;
      key = $urandom;
      lo  = 16'($urandom) & 16'hFFFE;
      run_fetch(lo, 16'($urandom), (t % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule